// File: doc/BRIEF.md
# DDS Parallel Control-Word Loader

This block is the byte-wide programming front end of a direct digital synthesizer. A host puts one byte at a time on an 8-bit bus and pulses a write clock for each byte. Five bytes make a complete programming set. The first byte holds a 5-bit phase offset, a power-down flag and two control bits. The next four bytes hold a 32-bit frequency tuning word, most significant byte first. The bytes collect in a holding register. Bytes that are not rewritten keep their previous contents.

A separate update strobe commits the holding register to the synthesizer core. The strobe is asynchronous to the reference clock. It is synchronized in the reference-clock domain and reduced to a single pulse. That pulse loads two delay lines, one for the tuning word and one for the phase, so each value reaches its output port after its own fixed latency.

An update whose control bits hold a reserved test code is rejected and reported on a flag. An update with the power-down flag set freezes both outputs and raises a power-down output.

Top module: `dds_ctrl_loader`

## Requirements
- R1: After reset, `ftw_out`, `phase_out`, `pwr_down` and `test_code` are all zero.
- R2: The first byte after an update (word 0) is split as follows: bits [7:3] are the phase offset (bit 7 is the MSB), bit 2 is the power-down flag, and bits [1:0] are the control code. A committed word 0 with power-down 0 and a normal code drives bits [7:3] onto `phase_out`.
- R3: Words 1 to 4 fill the tuning word most significant byte first. Word 1 lands in bits [31:24] and word 4 lands in bits [7:0].
- R4: An update may follow any number of words. A word that was not rewritten since the last update keeps its earlier holding-register value.
- R5: Write-clock edges after word 4 and before the next update leave the holding register unchanged.
- R6: The word pointer returns to word 0 on reset and while `upd` is high. The next write after an update lands in word 0.
- R7: A committed tuning word appears on `ftw_out` at the 20th rising `clk` edge after `upd` rises (2 synchronizer stages plus 18). Until then the output shows the previous value.
- R8: A committed phase appears on `phase_out` at the 15th rising `clk` edge after `upd` rises (2 plus 13). Until then the output shows the previous value.
- R9: Control codes 2'b01 and 2'b10 are reserved. An update that carries one of them sets `test_code` and leaves `ftw_out`, `phase_out` and `pwr_down` unchanged. An update with code 2'b00 or 2'b11 clears `test_code`.
- R10: An accepted update with power-down 1 sets `pwr_down` and holds `ftw_out` and `phase_out` at their last values. The next accepted update with power-down 0 clears `pwr_down` and loads the new values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wclk | input | 1 | Write clock; each rising edge captures one byte |
| wdata | input | 8 | Programming byte |
| upd | input | 1 | Update strobe, asynchronous to `clk` |
| ftw_out | output | 32 | Delayed frequency tuning word |
| phase_out | output | 5 | Delayed phase offset |
| pwr_down | output | 1 | Power-down state of the last accepted update |
| test_code | output | 1 | The last update carried a reserved control code |

## Verification
The bench builds the block with its default parameters: an 8-bit bus, a 32-bit tuning word, a 5-bit phase, latencies of 18 and 13, and two synchronizer stages. With these widths, a sweep over all 256 values of word 0 covers every phase, both power-down states and all four control codes, so entering and leaving power-down and every reserved code are exercised. Partial loads, overlong loads and edge-by-edge latency counts then test the pointer and the two delay lines against a byte-level model kept in the bench.

// File: rtl/dds_ldr_pkg.sv
package dds_ldr_pkg;

    localparam int BYTE_W = 8;
    localparam int PH_W   = 5;

    typedef enum logic [1:0] {
        CODE_NORMAL  = 2'b00,
        CODE_TEST_A  = 2'b01,
        CODE_TEST_B  = 2'b10,
        CODE_NORMAL2 = 2'b11
    } ctl_code_e;

    // Fields of the first word of a programming set
    typedef struct packed {
        logic [PH_W-1:0] phase;
        logic            pdn;
        ctl_code_e       code;
    } word0_t;

    function automatic logic is_reserved(input ctl_code_e c);
        return (c == CODE_TEST_A) || (c == CODE_TEST_B);
    endfunction

endpackage

// File: rtl/dds_word_collector.sv
module dds_word_collector
    import dds_ldr_pkg::*;
#(
    parameter int FTW_W = 32
) (
    input  logic               wclk,
    input  logic               rst_n,
    input  logic               upd,
    input  logic [BYTE_W-1:0]  wdata,
    output word0_t             hold_w0,
    output logic [FTW_W-1:0]   hold_ftw
);
    localparam int N_FBYTES  = FTW_W / BYTE_W;
    localparam int NUM_WORDS = N_FBYTES + 1;
    localparam int PTR_W     = $clog2(NUM_WORDS + 1);

    typedef struct packed {
        word0_t             w0;
        logic [FTW_W-1:0]   ftw;
    } hold_t;

    logic [PTR_W-1:0] ptr_d, ptr_q;
    hold_t            hold_d, hold_q;
    logic             ptr_clr;

    assign ptr_clr = !rst_n || upd;

    always_comb begin
        hold_d = hold_q;
        ptr_d  = ptr_q;
        if (ptr_q < PTR_W'(NUM_WORDS)) begin
            ptr_d = ptr_q + 1'b1;
            if (ptr_q == '0) begin
                hold_d.w0 = word0_t'(wdata);
            end else begin
                for (int k = 1; k <= N_FBYTES; k++) begin
                    if (ptr_q == PTR_W'(k))
                        hold_d.ftw[FTW_W-1-BYTE_W*(k-1) -: BYTE_W] = wdata;
                end
            end
        end
    end

    // Pointer is cleared asynchronously by reset or by the update strobe
    always_ff @(posedge wclk or posedge ptr_clr) begin
        if (ptr_clr) ptr_q <= '0;
        else         ptr_q <= ptr_d;
    end

    always_ff @(posedge wclk or negedge rst_n) begin
        if (!rst_n) hold_q <= '0;
        else        hold_q <= hold_d;
    end

    assign hold_w0  = hold_q.w0;
    assign hold_ftw = hold_q.ftw;

    AST_PTR_BOUND: assert property (@(posedge wclk) disable iff (ptr_clr)
        ptr_q <= PTR_W'(NUM_WORDS)); // R5

    AST_FULL_FROZEN: assert property (@(posedge wclk) disable iff (ptr_clr)
        ptr_q == PTR_W'(NUM_WORDS) |=> $stable(hold_q)); // R5

endmodule

// File: rtl/dds_upd_sync.sv
module dds_upd_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic upd_async,
    output logic upd_pulse
);
    typedef struct packed {
        logic [STAGES-1:0] sync;
        logic              last;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.sync = {s_q.sync[STAGES-2:0], upd_async};
        s_d.last = s_q.sync[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign upd_pulse = s_q.sync[STAGES-1] && !s_q.last;

    AST_ONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        upd_pulse |=> !upd_pulse); // R7

endmodule

// File: rtl/dds_delay_line.sv
module dds_delay_line #(
    parameter int W     = 32,
    parameter int DEPTH = 18
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         en,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] st_d [DEPTH];
    logic [W-1:0] st_q [DEPTH];

    always_comb begin
        st_d = st_q;
        if (load) st_d[0] = din;
        if (en) begin
            for (int i = 1; i < DEPTH; i++) st_d[i] = st_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) st_q[i] <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dout = st_q[DEPTH-1];

    AST_FROZEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !load) |=> $stable(dout)); // R10

endmodule

// File: rtl/dds_ctrl_loader.sv
module dds_ctrl_loader
    import dds_ldr_pkg::*;
#(
    parameter int FTW_W       = 32,
    parameter int FREQ_LAT    = 18,
    parameter int PHASE_LAT   = 13,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wclk,
    input  logic [7:0]        wdata,
    input  logic              upd,
    output logic [FTW_W-1:0]  ftw_out,
    output logic [4:0]        phase_out,
    output logic              pwr_down,
    output logic              test_code
);
    typedef struct packed {
        logic pdn;
        logic flag;
    } act_t;

    word0_t           hold_w0;
    logic [FTW_W-1:0] hold_ftw;
    logic             upd_pulse;
    logic             rsv;
    logic             load;
    act_t             a_d, a_q;

    dds_word_collector #(.FTW_W(FTW_W)) i_collect (
        .wclk     (wclk),
        .rst_n    (rst_n),
        .upd      (upd),
        .wdata    (wdata),
        .hold_w0  (hold_w0),
        .hold_ftw (hold_ftw)
    );

    dds_upd_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .upd_async (upd),
        .upd_pulse (upd_pulse)
    );

    always_comb begin
        rsv  = is_reserved(hold_w0.code);
        load = upd_pulse && !rsv && !hold_w0.pdn;
        a_d  = a_q;
        if (upd_pulse) begin
            a_d.flag = rsv;
            if (!rsv) a_d.pdn = hold_w0.pdn;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) a_q <= '0;
        else        a_q <= a_d;
    end

    dds_delay_line #(.W(FTW_W), .DEPTH(FREQ_LAT)) i_freq_dl (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load),
        .en    (!a_q.pdn),
        .din   (hold_ftw),
        .dout  (ftw_out)
    );

    dds_delay_line #(.W(PH_W), .DEPTH(PHASE_LAT)) i_phase_dl (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load),
        .en    (!a_q.pdn),
        .din   (hold_w0.phase),
        .dout  (phase_out)
    );

    assign pwr_down  = a_q.pdn;
    assign test_code = a_q.flag;

    AST_RSV_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_pulse && rsv) |=> test_code); // R9

    AST_RSV_KEEPS_PD: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_pulse && rsv) |=> $stable(pwr_down)); // R9

    AST_PD_HOLDS_FTW: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_down && $past(pwr_down)) |-> ($stable(ftw_out) && $stable(phase_out))); // R10

endmodule

// File: tb/test_dds_ctrl_loader.sv
`timescale 1ns/1ps
module test_dds_ctrl_loader;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wclk = 1'b0;
    logic [7:0]  wdata = '0;
    logic        upd = 1'b0;
    logic [31:0] ftw_out;
    logic [4:0]  phase_out;
    logic        pwr_down;
    logic        test_code;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    // bench model
    logic [7:0]  m_hold [5];
    int          m_ptr = 0;
    logic [31:0] e_ftw = '0;
    logic [4:0]  e_ph = '0;
    logic        e_pd = 1'b0;
    logic        e_flag = 1'b0;

    always #5 clk = ~clk;

    dds_ctrl_loader i_dds_ctrl_loader (
        .clk(clk), .rst_n(rst_n), .wclk(wclk), .wdata(wdata), .upd(upd),
        .ftw_out(ftw_out), .phase_out(phase_out),
        .pwr_down(pwr_down), .test_code(test_code)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] b);
        wdata = b;
        #3 wclk = 1'b1;
        #3 wclk = 1'b0;
        if (m_ptr < 5) begin
            m_hold[m_ptr] = b;
            m_ptr++;
        end
    endtask

    task automatic model_commit();
        logic [1:0] c;
        c = m_hold[0][1:0];
        m_ptr = 0;
        if (c == 2'b01 || c == 2'b10) begin
            e_flag = 1'b1;
        end else begin
            e_flag = 1'b0;
            e_pd = m_hold[0][2];
            if (!m_hold[0][2]) begin
                e_ftw = {m_hold[1], m_hold[2], m_hold[3], m_hold[4]};
                e_ph = m_hold[0][7:3];
            end
        end
    endtask

    // update and wait long enough for both delay lines to settle
    task automatic commit_settle();
        @(negedge clk);
        upd = 1'b1;
        repeat (3) @(negedge clk);
        upd = 1'b0;
        model_commit();
        repeat (24) @(negedge clk);
    endtask

    task automatic check_all(input string tag);
        chk({tag, " ftw"}, 64'(ftw_out), 64'(e_ftw));
        chk({tag, " phase"}, 64'(phase_out), 64'(e_ph));
        chk({tag, " pwr_down"}, 64'(pwr_down), 64'(e_pd));
        chk({tag, " test_code"}, 64'(test_code), 64'(e_flag));
    endtask

    initial begin
        #2000000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 5; i++) m_hold[i] = '0;
        repeat (3) @(negedge clk);
        // R1 reset state
        check_all("R1");
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R2 R3 R9 R10 sweep over every word-0 value
        for (int w = 0; w < 256; w++) begin
            logic [31:0] f;
            f = (32'(w) * 32'h01030507) ^ 32'hA5C3_1E69;
            wr(8'(w));
            wr(f[31:24]); wr(f[23:16]); wr(f[15:8]); wr(f[7:0]);
            commit_settle();
            check_all("R2/R3/R9/R10");
        end

        // leave in a known accepted, powered state
        wr(8'b10101_0_00); wr(8'h12); wr(8'h34); wr(8'h56); wr(8'h78);
        commit_settle();
        chk("R3 byte order", 64'(ftw_out), 64'h12345678);
        chk("R2 phase field", 64'(phase_out), 64'(5'b10101));

        // R4 partial load: only W0 and W1 rewritten
        wr(8'b00111_0_11); wr(8'hAB);
        commit_settle();
        chk("R4 partial ftw", 64'(ftw_out), 64'hAB345678);
        chk("R4 partial phase", 64'(phase_out), 64'(5'b00111));
        chk("R9 code 11 accepted", 64'(test_code), 64'd0);

        // R5 extra words ignored
        wr(8'b01100_0_00); wr(8'h01); wr(8'h02); wr(8'h03); wr(8'h04);
        wr(8'hFF); wr(8'hEE); wr(8'b11111_1_10);
        commit_settle();
        chk("R5 extra words ignored ftw", 64'(ftw_out), 64'h01020304);
        chk("R5 extra words ignored phase", 64'(phase_out), 64'(5'b01100));
        chk("R5 pwr_down", 64'(pwr_down), 64'd0);

        // R6 pointer back at W0: a single write changes only phase
        wr(8'b10001_0_00);
        commit_settle();
        chk("R6 single write lands in W0", 64'(phase_out), 64'(5'b10001));
        chk("R6 ftw kept", 64'(ftw_out), 64'h01020304);

        // R7 R8 edge-exact latency
        wr(8'b01010_0_00); wr(8'hDE); wr(8'hAD); wr(8'hBE); wr(8'hEF);
        @(negedge clk);
        upd = 1'b1;
        for (int n = 1; n <= 22; n++) begin
            @(posedge clk);
            #1;
            if (n == 14) chk("R8 phase old at edge 14", 64'(phase_out), 64'(5'b10001));
            if (n == 15) chk("R8 phase new at edge 15", 64'(phase_out), 64'(5'b01010));
            if (n == 19) chk("R7 ftw old at edge 19", 64'(ftw_out), 64'h01020304);
            if (n == 20) chk("R7 ftw new at edge 20", 64'(ftw_out), 64'hDEADBEEF);
        end
        upd = 1'b0;
        model_commit();
        repeat (4) @(negedge clk);

        // R9 reserved code: nothing changes but the flag
        wr(8'b11111_1_01); wr(8'h99); wr(8'h99); wr(8'h99); wr(8'h99);
        commit_settle();
        check_all("R9 reserved 01");
        chk("R9 flag set", 64'(test_code), 64'd1);

        // R10 power-down then resume
        wr(8'b00011_1_00); wr(8'h55); wr(8'h55); wr(8'h55); wr(8'h55);
        commit_settle();
        chk("R10 pd set", 64'(pwr_down), 64'd1);
        chk("R10 ftw frozen", 64'(ftw_out), 64'hDEADBEEF);
        wr(8'b00011_0_00);
        commit_settle();
        chk("R10 pd cleared", 64'(pwr_down), 64'd0);
        chk("R10 resumed ftw", 64'(ftw_out), 64'h55555555);
        chk("R10 resumed phase", 64'(phase_out), 64'(5'b00011));

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule